// File: doc/BRIEF.md
# Two-Port Shared Memory Collision Arbiter

This block sits in front of a 1024 x 8 storage array that two independent requesters, called left and right, can read and write at the same time. Each side presents an enable, a write strobe, an address and write data, and receives registered read data plus a BUSY flag. When both sides are enabled on the same location, the arbiter grants the location to the side that was there first. It flags BUSY to the other side and keeps that side from writing. If both arrive in the same clock cycle, left wins.

The block is built in one of two modes, chosen by a parameter. As a master it computes BUSY itself. As a slave it takes BUSY from outside on the `*_busy_ext` inputs, so that several arrays can share one master's decision and together form a wider word. In both modes a blocked reader keeps its last read data until the collision is over, or until it changes what it is asking for.

Top module: `dpc_arbiter`

## Requirements
- R1: Either side can write any of the 1024 locations and read any of them back. Read data appears on `*_rdata` one clock after a read cycle (enable 1, write strobe 0). A read in the same cycle as a write to the same location returns the old contents.
- R2: In master mode a side's BUSY is 1 only in the clock after a cycle in which both enables were 1 and both addresses were equal. This includes the case where the second enable rises onto an address that already matches.
- R3: A side counts as settled when its enable was 1 and its address unchanged in the previous cycle. When a match arises and exactly one side is settled, that side wins and the other side gets BUSY. The winner keeps the location for as long as the match lasts.
- R4: When a match arises and neither side is settled, as when both arrive in the same cycle, the left side wins and the right side gets BUSY.
- R5: BUSY returns to 0 one clock after a cycle in which the addresses differ or either enable is 0.
- R6: In master mode the losing side's write is dropped in the very cycle the collision is decided, so a colliding write never reaches the array.
- R7: A side that is reading while its BUSY is 1 keeps its previous read data. It loads new data once BUSY is 0, its address changes, its enable rises again, or its write strobe falls.
- R8: The array is written only in cycles where the enable and the write strobe of a side are both 1.
- R9: Two reads of the same location in the same cycle both return the stored data in the next clock, and BUSY is still flagged to the loser.
- R10: In slave mode each BUSY output follows its `*_busy_ext` input. A side's write is dropped, and its read is held as in R7, while that input is 1.
- R11: In master mode at most one BUSY output is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_en | input | 1 | Left side enable |
| lt_we | input | 1 | Left side write strobe |
| lt_addr | input | 10 | Left side address |
| lt_wdata | input | 8 | Left side write data |
| lt_busy_ext | input | 1 | Left BUSY from a master (slave mode only) |
| lt_rdata | output | 8 | Left side registered read data |
| lt_busy | output | 1 | Left BUSY flag, active high |
| rt_en | input | 1 | Right side enable |
| rt_we | input | 1 | Right side write strobe |
| rt_addr | input | 10 | Right side address |
| rt_wdata | input | 8 | Right side write data |
| rt_busy_ext | input | 1 | Right BUSY from a master (slave mode only) |
| rt_rdata | output | 8 | Right side registered read data |
| rt_busy | output | 1 | Right BUSY flag, active high |

## Verification
The assertions check the following rules on every cycle:
- BUSY is never raised to both sides at once.
- BUSY is raised only after a real match.
- BUSY clears after a mismatch.
- The winner keeps the location while the match lasts.
- A same-cycle arrival goes to the left side.
- A blocked reader's data stays put.

Some behaviour shows only at the array, and only the bench's scenarios can reveal it: that a losing or externally blocked write truly never landed, that a held reader later picks up the value the winner wrote, and that slave gating follows the external flags. The bench finds these by reading locations back and by comparing against a behavioural model on every clock.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_LT   = 2'd1,
        OWN_RT   = 2'd2
    } owner_e;
endpackage

// File: rtl/dpc_port_ctl.sv
module dpc_port_ctl #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_block,
    input  logic              rd_block,
    output logic              steady,
    output logic              wr_go,
    output logic              rd_go
);
    typedef struct packed {
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
    } side_st_t;

    side_st_t st_d, st_q;

    always_comb begin
        st_d.en   = en;
        st_d.we   = we;
        st_d.addr = addr;
        steady    = en & st_q.en & (addr == st_q.addr);
        wr_go     = en & we & ~wr_block;
        rd_go     = en & ~we &
                    (~rd_block | ~st_q.en | st_q.we | (addr != st_q.addr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dpc_prio.sv
module dpc_prio
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_en,
    input  logic              rt_en,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              lt_steady,
    input  logic              rt_steady,
    output logic              lt_lose,
    output logic              rt_lose,
    output logic              lt_busy_q,
    output logic              rt_busy_q
);
    typedef struct packed {
        owner_e owner;
        logic   lt_busy;
        logic   rt_busy;
    } prio_st_t;

    prio_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        hit  = lt_en & rt_en & (lt_addr == rt_addr);
        st_d = st_q;
        if (!hit) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner != OWN_NONE) begin
            st_d.owner = st_q.owner;
        end else if (rt_steady && !lt_steady) begin
            st_d.owner = OWN_RT;
        end else begin
            st_d.owner = OWN_LT;
        end
        st_d.lt_busy = (st_d.owner == OWN_RT);
        st_d.rt_busy = (st_d.owner == OWN_LT);
        lt_lose      = st_d.lt_busy;
        rt_lose      = st_d.rt_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, lt_busy: 1'b0, rt_busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lt_busy_q = st_q.lt_busy;
    assign rt_busy_q = st_q.rt_busy;
endmodule

// File: rtl/dpc_mem.sv
module dpc_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_wr,
    input  logic              lt_rd,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_wdata,
    output logic [DATA_W-1:0] lt_rdata,
    input  logic              rt_wr,
    input  logic              rt_rd,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] lt;
        logic [DATA_W-1:0] rt;
    } rd_st_t;

    logic [DATA_W-1:0] cells [DEPTH];
    rd_st_t            rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (rt_wr) cells[rt_addr] <= rt_wdata;
        if (lt_wr) cells[lt_addr] <= lt_wdata;
    end

    always_comb begin
        rd_d = rd_q;
        if (lt_rd) rd_d.lt = cells[lt_addr];
        if (rt_rd) rd_d.rt = cells[rt_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign lt_rdata = rd_q.lt;
    assign rt_rdata = rd_q.rt;
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_en,
    input  logic              lt_we,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_wdata,
    input  logic              lt_busy_ext,
    output logic [DATA_W-1:0] lt_rdata,
    output logic              lt_busy,
    input  logic              rt_en,
    input  logic              rt_we,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    input  logic              rt_busy_ext,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_busy
);
    logic lt_steady, rt_steady;
    logic lt_lose, rt_lose;
    logic lt_busy_q, rt_busy_q;
    logic lt_wr_block, rt_wr_block;
    logic lt_wr_go, rt_wr_go, lt_rd_go, rt_rd_go;

    dpc_prio #(.ADDR_W(ADDR_W)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .lt_en     (lt_en),
        .rt_en     (rt_en),
        .lt_addr   (lt_addr),
        .rt_addr   (rt_addr),
        .lt_steady (lt_steady),
        .rt_steady (rt_steady),
        .lt_lose   (lt_lose),
        .rt_lose   (rt_lose),
        .lt_busy_q (lt_busy_q),
        .rt_busy_q (rt_busy_q)
    );

    // Mode select: master uses its own decision, slave follows the external flags.
    assign lt_wr_block = IS_MASTER ? lt_lose   : lt_busy_ext;
    assign rt_wr_block = IS_MASTER ? rt_lose   : rt_busy_ext;
    assign lt_busy     = IS_MASTER ? lt_busy_q : lt_busy_ext;
    assign rt_busy     = IS_MASTER ? rt_busy_q : rt_busy_ext;

    dpc_port_ctl #(.ADDR_W(ADDR_W)) u_lt_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (lt_en),
        .we       (lt_we),
        .addr     (lt_addr),
        .wr_block (lt_wr_block),
        .rd_block (lt_busy),
        .steady   (lt_steady),
        .wr_go    (lt_wr_go),
        .rd_go    (lt_rd_go)
    );

    dpc_port_ctl #(.ADDR_W(ADDR_W)) u_rt_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rt_en),
        .we       (rt_we),
        .addr     (rt_addr),
        .wr_block (rt_wr_block),
        .rd_block (rt_busy),
        .steady   (rt_steady),
        .wr_go    (rt_wr_go),
        .rd_go    (rt_rd_go)
    );

    dpc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .lt_wr    (lt_wr_go),
        .lt_rd    (lt_rd_go),
        .lt_addr  (lt_addr),
        .lt_wdata (lt_wdata),
        .lt_rdata (lt_rdata),
        .rt_wr    (rt_wr_go),
        .rt_rd    (rt_rd_go),
        .rt_addr  (rt_addr),
        .rt_wdata (rt_wdata),
        .rt_rdata (rt_rdata)
    );
endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter bit IS_MASTER = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lt_en,
    input logic              lt_we,
    input logic [ADDR_W-1:0] lt_addr,
    input logic [DATA_W-1:0] lt_rdata,
    input logic              lt_busy,
    input logic              rt_en,
    input logic              rt_we,
    input logic [ADDR_W-1:0] rt_addr,
    input logic [DATA_W-1:0] rt_rdata,
    input logic              rt_busy
);
    logic armed_q;
    logic hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign hit = lt_en && rt_en && (lt_addr == rt_addr);

    // R7
    lt_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && lt_en && !lt_we && lt_busy && $past(lt_en) && !$past(lt_we)
        && (lt_addr == $past(lt_addr)) |=> $stable(lt_rdata));

    // R7
    rt_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && rt_en && !rt_we && rt_busy && $past(rt_en) && !$past(rt_we)
        && (rt_addr == $past(rt_addr)) |=> $stable(rt_rdata));

    generate
        if (IS_MASTER) begin : g_master
            // R11
            one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({lt_busy, rt_busy}));

            // R2
            busy_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                armed_q && (lt_busy || rt_busy) |-> $past(hit));

            // R5
            busy_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !hit |=> !lt_busy && !rt_busy);

            // R3
            owner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rt_busy && hit |=> rt_busy);

            // R4
            tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
                armed_q && hit && !$past(lt_en) && !$past(rt_en) |=> rt_busy && !lt_busy);
        end
    endgenerate
endmodule

bind dpc_arbiter dpc_arbiter_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IS_MASTER (IS_MASTER)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lt_en    (lt_en),
    .lt_we    (lt_we),
    .lt_addr  (lt_addr),
    .lt_rdata (lt_rdata),
    .lt_busy  (lt_busy),
    .rt_en    (rt_en),
    .rt_we    (rt_we),
    .rt_addr  (rt_addr),
    .rt_rdata (rt_rdata),
    .rt_busy  (rt_busy)
);

// File: tb/dpc_arbiter_tb.sv
`timescale 1ns/1ps
module dpc_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       len = 0, lwe = 0, ren = 0, rwe = 0;
    logic [9:0] la = 0, ra = 0;
    logic [7:0] lwd = 0, rwd = 0;
    logic       sbl = 0, sbr = 0;
    logic       zero = 1'b0;

    logic [7:0] m_lrd_o, m_rrd_o, s_lrd_o, s_rrd_o;
    logic       m_bl_o, m_br_o, s_bl_o, s_br_o;

    int vectors = 0;
    int misses  = 0;

    always #10 clk = ~clk;

    dpc_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .lt_en(len), .lt_we(lwe), .lt_addr(la), .lt_wdata(lwd), .lt_busy_ext(zero),
        .lt_rdata(m_lrd_o), .lt_busy(m_bl_o),
        .rt_en(ren), .rt_we(rwe), .rt_addr(ra), .rt_wdata(rwd), .rt_busy_ext(zero),
        .rt_rdata(m_rrd_o), .rt_busy(m_br_o)
    );

    dpc_arbiter #(.IS_MASTER(1'b0)) u_slv (
        .clk(clk), .rst_n(rst_n),
        .lt_en(len), .lt_we(lwe), .lt_addr(la), .lt_wdata(lwd), .lt_busy_ext(sbl),
        .lt_rdata(s_lrd_o), .lt_busy(s_bl_o),
        .rt_en(ren), .rt_we(rwe), .rt_addr(ra), .rt_wdata(rwd), .rt_busy_ext(sbr),
        .rt_rdata(s_rrd_o), .rt_busy(s_br_o)
    );

    // Behavioural reference model
    logic [7:0] m_mem [1024];
    logic [7:0] s_mem [1024];
    int         m_own;
    logic       m_bl, m_br;
    logic [7:0] m_lrd, m_rrd, s_lrd, s_rrd;
    logic       p_len, p_ren, p_lwe, p_rwe;
    logic [9:0] p_la, p_ra;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_own = 0; m_bl = 0; m_br = 0;
            m_lrd = 0; m_rrd = 0; s_lrd = 0; s_rrd = 0;
            p_len = 0; p_ren = 0; p_lwe = 0; p_rwe = 0; p_la = 0; p_ra = 0;
        end else begin
            logic hit, ls, rs, lw, rw, lr, rr, chg_l, chg_r;
            int   nown;
            hit   = len && ren && (la == ra);
            ls    = len && p_len && (la == p_la);
            rs    = ren && p_ren && (ra == p_ra);
            chg_l = !p_len || p_lwe || (la != p_la);
            chg_r = !p_ren || p_rwe || (ra != p_ra);
            if (!hit)              nown = 0;
            else if (m_own != 0)   nown = m_own;
            else if (rs && !ls)    nown = 2;
            else                   nown = 1;
            // master side
            lw = len && lwe && (nown != 2);
            rw = ren && rwe && (nown != 1);
            lr = len && !lwe && (!m_bl || chg_l);
            rr = ren && !rwe && (!m_br || chg_r);
            if (lr) m_lrd = m_mem[la];
            if (rr) m_rrd = m_mem[ra];
            if (rw) m_mem[ra] = rwd;
            if (lw) m_mem[la] = lwd;
            m_own = nown;
            m_bl  = (nown == 2);
            m_br  = (nown == 1);
            // slave side
            lw = len && lwe && !sbl;
            rw = ren && rwe && !sbr;
            lr = len && !lwe && (!sbl || chg_l);
            rr = ren && !rwe && (!sbr || chg_r);
            if (lr) s_lrd = s_mem[la];
            if (rr) s_rrd = s_mem[ra];
            if (rw) s_mem[ra] = rwd;
            if (lw) s_mem[la] = lwd;
            p_len = len; p_ren = ren; p_lwe = lwe; p_rwe = rwe; p_la = la; p_ra = ra;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 R7 master left rdata",  m_lrd_o, m_lrd);
        chk("R1 R7 master right rdata", m_rrd_o, m_rrd);
        chk("R2 R3 R5 master left busy",  {7'd0, m_bl_o}, {7'd0, m_bl});
        chk("R2 R3 R5 master right busy", {7'd0, m_br_o}, {7'd0, m_br});
        chk("R10 slave left rdata",  s_lrd_o, s_lrd);
        chk("R10 slave right rdata", s_rrd_o, s_rrd);
        chk("R10 slave left busy",  {7'd0, s_bl_o}, {7'd0, sbl});
        chk("R10 slave right busy", {7'd0, s_br_o}, {7'd0, sbr});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R2 reset left busy", {7'd0, m_bl_o}, 8'd0);
        chk("R2 reset right busy", {7'd0, m_br_o}, 8'd0);
        chk("R1 reset rdata", m_lrd_o, 8'd0);

        // fill both arrays through the left side
        for (int a = 0; a < 1024; a++) begin
            len = 1; lwe = 1; la = 10'(a); lwd = pat(a);
            tick();
        end
        len = 0; lwe = 0;

        // R1: plain read and write from the right side
        ren = 1; ra = 10'd7; tick();
        chk("R1 right read", m_rrd_o, pat(7));
        rwe = 1; ra = 10'd300; rwd = 8'hC3; tick();
        rwe = 0; tick();
        chk("R1 right readback", m_rrd_o, 8'hC3);

        // R3 / R6: left settled on 20, right arrives with a write
        len = 1; la = 10'd20; tick();
        ra = 10'd20; rwe = 1; rwd = 8'hEE; tick();
        chk("R3 settled left wins", {7'd0, m_br_o}, 8'd1);
        chk("R3 left not flagged", {7'd0, m_bl_o}, 8'd0);
        rwe = 0; len = 0; ren = 0; tick();
        chk("R5 clear on enable drop", {7'd0, m_br_o}, 8'd0);
        ren = 1; tick();
        chk("R6 losing write dropped", m_rrd_o, pat(20));

        // R3 / R7: right settled on 40, left collides, then a held read
        ra = 10'd40; tick();
        len = 1; la = 10'd40; lwe = 1; lwd = 8'h11; tick();
        chk("R3 settled right wins", {7'd0, m_bl_o}, 8'd1);
        lwe = 0; tick();
        rwe = 1; rwd = 8'h99; tick();
        rwe = 0; tick();
        chk("R7 blocked read held", m_lrd_o, pat(40));
        ren = 0; tick();
        tick();
        chk("R7 read after release", m_lrd_o, 8'h99);
        chk("R5 busy released", {7'd0, m_bl_o}, 8'd0);

        // R4 / R9: same-cycle arrival of two reads
        len = 0; tick();
        len = 1; ren = 1; la = 10'd77; ra = 10'd77; tick();
        chk("R4 tie goes left", {7'd0, m_br_o}, 8'd1);
        chk("R4 left clear", {7'd0, m_bl_o}, 8'd0);
        chk("R9 left read data", m_lrd_o, pat(77));
        chk("R9 right read data", m_rrd_o, pat(77));

        // R2: enable rising onto a matching address
        len = 0; ren = 0; la = 10'd90; ra = 10'd90; tick();
        len = 1; tick();
        ren = 1; tick();
        chk("R2 enable-raised busy", {7'd0, m_br_o}, 8'd1);
        ra = 10'd91; tick();
        chk("R2 no busy on mismatch", {7'd0, m_br_o}, 8'd0);
        ren = 0; len = 0; tick();

        // R8: strobe without enable writes nothing
        la = 10'd500; lwe = 1; lwd = 8'hFF; tick();
        lwe = 0; len = 1; tick();
        chk("R8 no write without enable", m_lrd_o, pat(500));
        len = 0; tick();

        // R10: external BUSY gates the slave write
        sbl = 1; len = 1; lwe = 1; la = 10'd600; lwd = 8'h42; tick();
        chk("R10 slave busy follows input", {7'd0, s_bl_o}, 8'd1);
        sbl = 0; lwe = 0; tick();
        chk("R10 slave write dropped", s_lrd_o, pat(600));
        chk("R10 master write landed", m_lrd_o, 8'h42);
        len = 0; tick();

        // mixed traffic over a few addresses
        for (int i = 0; i < 3000; i++) begin
            len = ($urandom_range(3) != 0);
            ren = ($urandom_range(3) != 0);
            lwe = ($urandom_range(9) < 3);
            rwe = ($urandom_range(9) < 3);
            la  = 10'($urandom_range(3));
            ra  = 10'($urandom_range(3));
            lwd = 8'($urandom);
            rwd = 8'($urandom);
            sbl = ($urandom_range(4) == 0);
            sbr = ($urandom_range(4) == 0);
            tick();
            chk("R11 single busy", {7'd0, m_bl_o & m_br_o}, 8'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule